// File: doc/BRIEF.md
# Frame-Locked Sync Watchdog

This block sits at the front of a video encoder running as a frame-locked slave. It watches an incoming odd/even field flag, uses only one edge direction of it (chosen by a polarity bit) as the frame reference, and produces the line sync internally from a free-running line counter. The first reference edge after reset starts line sync generation and encoding. After that, every later reference edge is expected exactly one frame period after the last frame start.

A small miss counter records failed checks. A check fails when the expected edge is absent or when an edge arrives off-schedule. On the third failure in a row the block declares loss of lock and applies one of three configured fallbacks:

- Free-run: everything continues as if the edges were present.
- Sync only: the picture is forced black while sync continues.
- Silence: the picture is black and no sync is produced.

Any reference edge seen while lock is lost restarts frame timing at that point. A programmable delay of 0 to 3 clocks on the incoming flag lets the integrator align the reference edge with the data stream.

Top module: `frame_sync_watchdog`

## Requirements
- R1: While reset is held and afterwards until the first reference edge, hsync_o, encode_o and sync_en_o are 0 and black_o is 1.
- R2: With edge_pol_i = 1 only a 0-to-1 transition of the (delayed) field flag is a reference edge; with edge_pol_i = 0 only a 1-to-0 transition is. The opposite transition has no effect on any output.
- R3: A delay setting dly_i of d (0..3) makes the block react to a field-flag transition exactly d clocks later than with d = 0.
- R4: After a reference edge that starts timing, the following cycle shows hsync_o = 1, encode_o = 1, sync_en_o = 1 and black_o = 0. hsync_o is then high for the first HS_WIDTH clocks of every LINE_LEN-clock line.
- R5: Frame and line timing restart every frame_len_i clocks, counted from the last frame start, whether or not the expected edge arrives. A reference edge arriving exactly at that instant is on time.
- R6: A missing expected edge, or a reference edge arriving at any other instant while locked, counts as one miss. An off-schedule edge does not re-align the timing. The third consecutive miss ends lock.
- R7: After loss of lock with free_run_i = 1, the outputs keep behaving exactly as when locked: hsync_o continues, encode_o = 1, sync_en_o = 1 and black_o = 0.
- R8: After loss of lock with free_run_i = 0 and sync_ok_i = 1, hsync_o keeps its line timing, sync_en_o = 1, encode_o = 0 and black_o = 1.
- R9: After loss of lock with free_run_i = 0 and sync_ok_i = 0, hsync_o = 0, sync_en_o = 0, encode_o = 0 and black_o = 1.
- R10: While lock is lost, any reference edge restarts frame and line timing in the next cycle, clears the miss count and returns the outputs to the locked behaviour.
- R11: A single on-time edge clears the miss count, so two misses, one on-time edge and two further misses leave the block locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_flag_i | input | 1 | Incoming odd/even field flag |
| edge_pol_i | input | 1 | 1: rising edge is the reference, 0: falling edge |
| dly_i | input | 2 | Delay applied to field_flag_i, in clocks (0..3) |
| free_run_i | input | 1 | Continue normal output after loss of lock |
| sync_ok_i | input | 1 | Keep sync (with black picture) after loss of lock when not free-running |
| frame_len_i | input | FRAME_W | Frame period in clocks (at least 2) |
| hsync_o | output | 1 | Internally generated line sync, active high |
| encode_o | output | 1 | Incoming video is being encoded |
| sync_en_o | output | 1 | Analog sync tips enabled |
| black_o | output | 1 | Active picture forced to black |

## Verification
The functions that collide are the expected-edge check and the arrival of a reference edge. Both can fall in the same clock, and either can also fall together with the third-miss transition to loss of lock.

The bench drives cadences in several ways: exactly on time, skipped frames, an edge half a frame early followed by an on-time one, and edges at arbitrary offsets while lock is lost. It does this under each fallback configuration and each delay setting.

A behavioural reference model advances on every clock, and all four outputs are compared against it on every cycle. Spot checks pin the expected values at the points where the model and the design could agree on something wrong.

// File: rtl/fsw_pkg.sv
// Shared types for the frame sync watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package fsw_pkg;

    // Lock state of the watchdog.
    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,   // waiting for the first reference edge
        ST_LOCK = 2'd1,   // timing anchored, edges being checked
        ST_LOST = 2'd2    // three consecutive misses seen
    } lock_st_e;

    localparam int unsigned MISS_LIMIT = 3;

endpackage

// File: rtl/fsw_edge_pick.sv
// Delays the field flag by 0..MAX_DLY clocks and flags the polarity-selected transition.
// Assumes: dly_i and edge_pol_i change only while the flag has been stable for MAX_DLY+1 clocks.
module fsw_edge_pick #(
    parameter int unsigned MAX_DLY = 3,
    localparam int unsigned DW = $clog2(MAX_DLY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flag_i,
    input  logic          pol_i,
    input  logic [DW-1:0] dly_i,
    output logic          edge_o
);

    logic [MAX_DLY-1:0] hist_q;
    logic [MAX_DLY:0]   taps;
    logic               tap;
    logic               prev_q;
    logic               primed_q;

    // Tap 0 is the live flag; tap i is the flag i clocks ago.
    assign taps[0] = flag_i;
    for (genvar i = 1; i <= MAX_DLY; i++) begin : g_tap
        assign taps[i] = hist_q[i-1];
    end

    assign tap = taps[dly_i];

    // Shift the flag history one place per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[MAX_DLY-2:0], flag_i};
        end
    end

    // Remember the previous delayed level; prime once a level has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= tap;
            primed_q <= 1'b1;
        end
    end

    // Only the transition towards the level named by pol_i counts.
    always_comb begin
        edge_o = primed_q && (tap != prev_q) && (tap == pol_i);
    end

    // R2: after a reported edge the remembered level equals the polarity.
    p_edge_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (prev_q == $past(pol_i)));

endmodule

// File: rtl/fsw_lock_ctl.sv
// Frame counter, three-strike miss counter and lock state machine.
// Assumes: frame_len_i >= 2 and held constant while locked.
module fsw_lock_ctl
    import fsw_pkg::*;
#(
    parameter int unsigned FRAME_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_i,
    input  logic [FRAME_W-1:0] frame_len_i,
    output lock_st_e           st_o,
    output logic               restart_o
);

    lock_st_e           st_q, st_d;
    logic [FRAME_W-1:0] fcnt_q, fcnt_d;
    logic [1:0]         miss_q, miss_d;
    logic               due;
    logic               fail;

    // The expected-edge instant: last clock of the current frame.
    always_comb begin
        due = (st_q != ST_SEEK) && (fcnt_q >= frame_len_i - 1'b1);
    end

    // A check fails when the due edge is absent or an edge comes off-schedule.
    always_comb begin
        fail = (st_q == ST_LOCK) && (due != edge_i);
    end

    // Next-state, frame counter and miss counter decisions.
    always_comb begin
        st_d      = st_q;
        fcnt_d    = fcnt_q;
        miss_d    = miss_q;
        restart_o = 1'b0;
        unique case (st_q)
            ST_SEEK: begin
                if (edge_i) begin
                    st_d      = ST_LOCK;
                    restart_o = 1'b1;
                    miss_d    = '0;
                end
            end
            ST_LOCK: begin
                restart_o = due;
                if (due && edge_i) begin
                    miss_d = '0;
                end else if (fail) begin
                    if (miss_q == 2'(MISS_LIMIT - 1)) begin
                        st_d   = ST_LOST;
                        miss_d = '0;
                    end else begin
                        miss_d = miss_q + 2'd1;
                    end
                end
            end
            ST_LOST: begin
                restart_o = due || edge_i;
                if (edge_i) begin
                    st_d   = ST_LOCK;
                    miss_d = '0;
                end
            end
            default: st_d = ST_SEEK;
        endcase
        if (restart_o) begin
            fcnt_d = '0;
        end else if (st_q != ST_SEEK) begin
            fcnt_d = fcnt_q + 1'b1;
        end
    end

    // Register state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_SEEK;
            fcnt_q <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            fcnt_q <= fcnt_d;
            miss_q <= miss_d;
        end
    end

    assign st_o = st_q;

    // R4: the first reference edge anchors timing.
    p_first_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEEK && edge_i) |=> (st_q == ST_LOCK && fcnt_q == '0));

    // R6: loss of lock only follows two recorded misses.
    p_third_strike_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_LOST) |-> ($past(miss_q) == 2'd2));

    // R6: the miss counter never reaches the limit while held.
    p_miss_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q != 2'd3);

    // R11: an on-time edge leaves the miss counter clear.
    p_hit_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCK && edge_i && fcnt_q == frame_len_i - 1'b1) |=> (miss_q == '0));

    // R10: an edge during loss of lock re-anchors timing.
    p_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOST && edge_i) |=> (st_q == ST_LOCK && fcnt_q == '0));

endmodule

// File: rtl/fsw_line_gen.sv
// Line counter and internal line sync pulse.
// Assumes: HS_WIDTH < LINE_LEN; restart_i re-anchors the line to count 0.
module fsw_line_gen #(
    parameter int unsigned LINE_LEN = 1728,
    parameter int unsigned HS_WIDTH = 128,
    localparam int unsigned LW = $clog2(LINE_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic hsync_o
);

    localparam logic [LW-1:0] LAST = LW'(LINE_LEN - 1);
    localparam logic [LW-1:0] HS_END = LW'(HS_WIDTH);

    logic [LW-1:0] lcnt_q;

    // Count clocks within a line; restart on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt_q <= '0;
        end else if (restart_i) begin
            lcnt_q <= '0;
        end else if (run_i) begin
            lcnt_q <= (lcnt_q == LAST) ? '0 : lcnt_q + 1'b1;
        end
    end

    // Pulse covers the first HS_WIDTH clocks of each line.
    always_comb begin
        hsync_o = run_i && (lcnt_q < HS_END);
    end

    // R5: after a restart the line sync is asserted.
    p_restart_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && run_i) |=> (lcnt_q == '0));

endmodule

// File: rtl/frame_sync_watchdog.sv
// Frame-locked slave sync watchdog: locks to one field-flag edge per frame,
// generates line sync internally and applies a fallback after three misses.
// Assumes: frame_len_i >= 2; configuration changed only while the flag is quiet.
module frame_sync_watchdog
    import fsw_pkg::*;
#(
    parameter int unsigned FRAME_W  = 21,
    parameter int unsigned LINE_LEN = 1728,
    parameter int unsigned HS_WIDTH = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_flag_i,
    input  logic               edge_pol_i,
    input  logic [1:0]         dly_i,
    input  logic               free_run_i,
    input  logic               sync_ok_i,
    input  logic [FRAME_W-1:0] frame_len_i,
    output logic               hsync_o,
    output logic               encode_o,
    output logic               sync_en_o,
    output logic               black_o
);

    logic     ref_edge;
    logic     restart;
    logic     line_hs;
    logic     running;
    lock_st_e st;

    fsw_edge_pick #(.MAX_DLY(3)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (field_flag_i),
        .pol_i  (edge_pol_i),
        .dly_i  (dly_i),
        .edge_o (ref_edge)
    );

    fsw_lock_ctl #(.FRAME_W(FRAME_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (ref_edge),
        .frame_len_i (frame_len_i),
        .st_o        (st),
        .restart_o   (restart)
    );

    assign running = (st != ST_SEEK);

    fsw_line_gen #(.LINE_LEN(LINE_LEN), .HS_WIDTH(HS_WIDTH)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (running),
        .restart_i (restart),
        .hsync_o   (line_hs)
    );

    // Map lock state and fallback configuration to the output flags.
    always_comb begin
        hsync_o   = 1'b0;
        encode_o  = 1'b0;
        sync_en_o = 1'b0;
        black_o   = 1'b1;
        unique case (st)
            ST_LOCK: begin
                hsync_o   = line_hs;
                encode_o  = 1'b1;
                sync_en_o = 1'b1;
                black_o   = 1'b0;
            end
            ST_LOST: begin
                if (free_run_i) begin
                    hsync_o   = line_hs;
                    encode_o  = 1'b1;
                    sync_en_o = 1'b1;
                    black_o   = 1'b0;
                end else if (sync_ok_i) begin
                    hsync_o   = line_hs;
                    sync_en_o = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R7: encoding never coincides with a forced black picture.
    p_enc_not_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        encode_o |-> !black_o);

    // R9: line sync is only driven while sync output is enabled.
    p_hs_needs_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_o |-> sync_en_o);

    // R1: before any lock nothing is encoded or synced.
    p_seek_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEEK) |-> (!encode_o && !sync_en_o && black_o));

endmodule

// File: tb/frame_sync_watchdog_tb.sv
module frame_sync_watchdog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 8;
    localparam int LL = 7;
    localparam int HW = 2;
    localparam int P  = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flag = 1'b0;
    logic          pol = 1'b1;
    logic [1:0]    dly = 2'd0;
    logic          frun = 1'b0;
    logic          sok = 1'b0;
    logic [FW-1:0] flen = FW'(P);
    logic          hs, enc, sen, blk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_st, m_fc, m_lc, m_miss, m_prev, m_primed;
    int m_h0, m_h1, m_h2;

    frame_sync_watchdog #(.FRAME_W(FW), .LINE_LEN(LL), .HS_WIDTH(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .field_flag_i(flag), .edge_pol_i(pol),
        .dly_i(dly), .free_run_i(frun), .sync_ok_i(sok), .frame_len_i(flen),
        .hsync_o(hs), .encode_o(enc), .sync_en_o(sen), .black_o(blk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void expect_bits(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        int tap, e, due;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_fc = 0; m_lc = 0; m_miss = 0;
            m_prev = 0; m_primed = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0;
        end else begin
            case (dly)
                2'd0: tap = flag;
                2'd1: tap = m_h0;
                2'd2: tap = m_h1;
                default: tap = m_h2;
            endcase
            e = (m_primed != 0 && tap != m_prev && tap == pol) ? 1 : 0;
            due = (m_st != 0 && m_fc >= P - 1) ? 1 : 0;
            if (m_st == 0) begin
                if (e != 0) begin m_st = 1; m_fc = 0; m_lc = 0; m_miss = 0; end
            end else if (m_st == 1) begin
                if (due != 0 && e != 0) m_miss = 0;
                else if (due != 0 || e != 0) begin
                    m_miss++;
                    if (m_miss == 3) begin m_st = 2; m_miss = 0; end
                end
                if (due != 0) begin m_fc = 0; m_lc = 0; end
                else begin m_fc++; m_lc = (m_lc + 1) % LL; end
            end else begin
                if (e != 0) begin m_st = 1; m_miss = 0; end
                if (e != 0 || due != 0) begin m_fc = 0; m_lc = 0; end
                else begin m_fc++; m_lc = (m_lc + 1) % LL; end
            end
            m_h2 = m_h1; m_h1 = m_h0; m_h0 = flag;
            m_prev = tap; m_primed = 1;
        end
    end

    // compare every cycle against the model
    always @(negedge clk) begin
        int ehs, een, ese, ebk;
        if (rst_n) begin
            ehs = 0; een = 0; ese = 0; ebk = 1;
            if (m_st == 1 || (m_st == 2 && frun)) begin
                ehs = (m_lc < HW); een = 1; ese = 1; ebk = 0;
            end else if (m_st == 2 && sok) begin
                ehs = (m_lc < HW); ese = 1;
            end
            expect_bits(cur_req, "hsync", hs, ehs);
            expect_bits(cur_req, "encode", enc, een);
            expect_bits(cur_req, "sync_en", sen, ese);
            expect_bits(cur_req, "black", blk, ebk);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    // one frame with its reference edge at the start
    task automatic frame(int n);
        flag = pol;
        tick(n / 2);
        flag = !pol;
        tick(n - n / 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    // lose lock by withholding three frames then spot-check the fallback
    task automatic lose(string req, int ee, int es, int eb);
        cur_req = req;
        tick(3 * P + 5);
        @(negedge clk);
        expect_bits(req, "fallback encode", enc, ee);
        expect_bits(req, "fallback sync_en", sen, es);
        expect_bits(req, "fallback black", blk, eb);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(2);
        @(negedge clk);
        expect_bits("R1", "reset encode", enc, 0);
        expect_bits("R1", "reset black", blk, 1);
        expect_bits("R1", "reset hsync", hs, 0);
        #1;
        rst_n = 1'b1;
        tick(5);
        // R2: falling transition ignored with rising polarity
        cur_req = "R2";
        flag = 1'b1; tick(1); flag = 1'b1;
        flag = 1'b0; tick(1);
        do_reset();
        flag = 1'b1; tick(6);
        flag = 1'b0; tick(6);
        @(negedge clk);
        expect_bits("R2", "opposite edge encode", enc, 0);
        expect_bits("R2", "opposite edge sync_en", sen, 0);
        #1;
        // R4: first edge locks
        cur_req = "R4";
        flag = 1'b1;
        @(negedge clk); @(negedge clk);
        expect_bits("R4", "lock encode", enc, 1);
        expect_bits("R4", "lock hsync", hs, 1);
        #1;
        tick(P / 2 - 1);
        flag = 1'b0;
        tick(P - P / 2 - 1);
        // R5: on-time frames
        cur_req = "R5";
        repeat (3) frame(P);
        // R11: two misses, hit, two misses
        cur_req = "R11";
        tick(2 * P);
        frame(P);
        tick(2 * P);
        @(negedge clk);
        expect_bits("R11", "still locked", enc, 1);
        #1;
        frame(P - 1);
        // R6: off-schedule edge, then an on-time edge
        cur_req = "R6";
        tick(1);
        frame(P / 2);
        frame(P - P / 2);
        frame(P);
        // R7: free-run fallback
        frun = 1'b1;
        lose("R7", 1, 1, 0);
        // R10: relock at an arbitrary offset
        cur_req = "R10";
        tick(7);
        frame(P);
        frame(P);
        // R8: sync-only fallback
        frun = 1'b0; sok = 1'b1;
        lose("R8", 0, 1, 1);
        cur_req = "R10";
        tick(4);
        frame(P);
        @(negedge clk);
        expect_bits("R10", "relock encode", enc, 1);
        #1;
        // R9: silent fallback
        sok = 1'b0;
        tick(P - 1);
        lose("R9", 0, 0, 1);
        @(negedge clk);
        expect_bits("R9", "silent hsync", hs, 0);
        #1;
        cur_req = "R10";
        frame(P);
        frame(P);
        // R3: delay settings shift the lock point
        for (int d = 0; d < 4; d++) begin
            cur_req = "R3";
            flag = 1'b0; dly = 2'(d);
            do_reset();
            tick(5);
            flag = 1'b1;
            for (int j = 0; j <= d + 1; j++) begin
                @(negedge clk);
                expect_bits("R3", "delayed lock", enc, (j == d + 1) ? 1 : 0);
            end
            #1;
            tick(P);
        end
        // R2: falling polarity
        cur_req = "R2";
        dly = 2'd0; pol = 1'b0; flag = 1'b0;
        do_reset();
        tick(5);
        flag = 1'b1; tick(4);
        @(negedge clk);
        expect_bits("R2", "rising ignored when falling selected", enc, 0);
        #1;
        flag = 1'b0;
        tick(1);
        @(negedge clk);
        expect_bits("R2", "falling locks", enc, 1);
        #1;
        tick(P - 2);
        repeat (2) frame(P);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule